// File: doc/BRIEF.md
# Conversion-Complete Flag Bank

This block holds one sticky "result ready" bit for each of the upper conversion slots of an ADC conversion sequence. With the default configuration these are slots 8 through 15. Each bit sets when the converter reports that the conversion at its slot has finished. Software reads the bits back as a read-only status byte. Slot 15 sits in bit 7 and slot 8 in bit 0. A 1 means the result for that slot is ready, and a 0 means that conversion has not completed.

A bit can be cleared in two ways, chosen by a fast-clear mode input.

- **Two-step mode (`fast_clr=0`):** a bit clears only when a status-byte read has armed it and a later read of that slot's result register follows. A status read arms only the bits that read as 1 at that moment. The arm is used up by the result read, and a new sequence start drops it.
- **Fast mode (`fast_clr=1`):** a result read alone clears the bit.

A write to the control register that starts a new sequence wipes every bit and every arm. The converter, the sequencer and the result storage sit outside the block.

Top module: `ccf_flag_bank`

## Requirements
- R1: After reset every bit of `flags` is 0.
- R2: An end-of-conversion strobe with `eoc_pos` = 8+i sets `flags[i]`, with slot 15 in bit 7 and slot 8 in bit 0. Strobes with `eoc_pos` below 8 change no bit.
- R3: A set bit stays 1 until a clear event that applies to it.
- R4: `seq_start_wr` clears every bit and every arm on the next edge. This holds even if a set strobe for the same bit arrives in that cycle.
- R5: With `fast_clr`=0, a result read of slot 8+i alone leaves `flags[i]` unchanged. A result read in a cycle after a status read that saw `flags[i]`=1 clears it.
- R6: With `fast_clr`=0, a status read arms only the bits that read 1 at that moment. A bit set after the status read is not cleared by its result read. An arm is used up by one result read, so after the bit is set again a further result read leaves it at 1.
- R7: With `fast_clr`=1, a result read of slot 8+i clears `flags[i]` with no status read.
- R8: When a set strobe and a result-read clear hit the same bit in one cycle, the bit ends at 1.
- R9: A status-register write, and result reads of slots 0 to 7, change no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc_valid | input | 1 | End-of-conversion strobe |
| eoc_pos | input | 4 | Sequence slot of the finished conversion |
| seq_start_wr | input | 1 | Write to the sequence-start control register |
| fast_clr | input | 1 | 1: result read alone clears; 0: status read then result read |
| stat_rd | input | 1 | Read strobe of the status byte |
| stat_wr | input | 1 | Write strobe of the status byte (no effect) |
| res_rd | input | 1 | Result-register read strobe |
| res_idx | input | 4 | Result register number being read |
| flags | output | 8 | Completion bits, slot 15 in bit 7 |

## Verification
The bench applies set strobes to every slot from 0 to 15. This separates correct slot-to-bit mapping from shifted or mirrored mappings, and confirms that low slots are ignored.

Result reads are swept over all sixteen indices in both modes:
- without a prior status read in two-step mode, which shows that a result read alone clears nothing;
- after a status read, which clears bits one by one.

A selective-arm pattern sets some bits after the status read and re-sets a bit after its arm has been used. This tells a per-bit, single-use arm apart from a global "status was read" latch. Same-cycle collisions of set with clear and with sequence start pin down the priority order.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

   // Shared per-cycle controls fanned out to every flag cell
   typedef struct packed {
      logic start;    // sequence start: wipe flag and arm
      logic fast;     // result read alone clears
      logic arm_req;  // status read in two-step mode
   } ccf_ctrl_t;

endpackage

// File: rtl/ccf_pos_decode.sv
module ccf_pos_decode #(
   parameter int N     = 8,
   parameter int BASE  = 8,
   parameter int IDX_W = 4
) (
   input  logic             valid,
   input  logic [IDX_W-1:0] idx,
   output logic [N-1:0]     hit
);

   if (BASE + N > (1 << IDX_W)) begin : g_bad_width
      $error("ccf_pos_decode: index width too small for window");
   end

   for (genvar i = 0; i < N; i++) begin : g_hit
      localparam logic [IDX_W-1:0] POS = IDX_W'(BASE + i);
      assign hit[i] = valid && (idx == POS);
   end

endmodule

// File: rtl/ccf_flag_cell.sv
module ccf_flag_cell
   import ccf_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ccf_ctrl_t ctrl,
   input  logic      set_hit,
   input  logic      res_hit,
   output logic      flag_q
);

   logic arm_q;
   logic clr;
   logic flag_d;
   logic arm_d;

   assign clr = res_hit && (ctrl.fast || arm_q);

   always_comb begin
      if (ctrl.start)      flag_d = 1'b0;
      else if (set_hit)    flag_d = 1'b1;
      else if (clr)        flag_d = 1'b0;
      else                 flag_d = flag_q;
   end

   always_comb begin
      if (ctrl.start)                     arm_d = 1'b0;
      else if (res_hit)                   arm_d = 1'b0;
      else if (ctrl.arm_req && flag_q)    arm_d = 1'b1;
      else                                arm_d = arm_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         flag_q <= flag_d;
         arm_q  <= arm_d;
      end
   end

   // R4
   start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.start |=> (!flag_q && !arm_q));

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hit && !ctrl.start) |=> flag_q);

   // R7
   fast_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.fast && res_hit && !set_hit && !ctrl.start) |=> !flag_q);

   // R5
   unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.fast && res_hit && !arm_q && !set_hit && !ctrl.start) |=> $stable(flag_q));

   // R5
   armed_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.fast && res_hit && arm_q && !set_hit && !ctrl.start) |=> !flag_q);

   // R6
   arm_only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !arm_q && !ctrl.start) |=> !arm_q);

endmodule

// File: rtl/ccf_flag_bank.sv
module ccf_flag_bank
   import ccf_pkg::*;
#(
   parameter int NUM_FLAGS = 8,
   parameter int BASE_POS  = 8,
   parameter int IDX_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 eoc_valid,
   input  logic [IDX_W-1:0]     eoc_pos,
   input  logic                 seq_start_wr,
   input  logic                 fast_clr,
   input  logic                 stat_rd,
   input  logic                 stat_wr,
   input  logic                 res_rd,
   input  logic [IDX_W-1:0]     res_idx,
   output logic [NUM_FLAGS-1:0] flags
);

   localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(BASE_POS);

   if (NUM_FLAGS < 1) begin : g_bad_count
      $error("ccf_flag_bank: NUM_FLAGS must be at least 1");
   end
   if (BASE_POS + NUM_FLAGS > (1 << IDX_W)) begin : g_bad_idx
      $error("ccf_flag_bank: IDX_W cannot address the flag window");
   end

   ccf_ctrl_t           ctrl;
   logic [NUM_FLAGS-1:0] set_hit;
   logic [NUM_FLAGS-1:0] res_hit;

   assign ctrl.start   = seq_start_wr;
   assign ctrl.fast    = fast_clr;
   assign ctrl.arm_req = stat_rd && !fast_clr;

   ccf_pos_decode #(.N(NUM_FLAGS), .BASE(BASE_POS), .IDX_W(IDX_W)) u_set_dec (
      .valid (eoc_valid),
      .idx   (eoc_pos),
      .hit   (set_hit)
   );

   ccf_pos_decode #(.N(NUM_FLAGS), .BASE(BASE_POS), .IDX_W(IDX_W)) u_res_dec (
      .valid (res_rd),
      .idx   (res_idx),
      .hit   (res_hit)
   );

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
      ccf_flag_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctrl    (ctrl),
         .set_hit (set_hit[i]),
         .res_hit (res_hit[i]),
         .flag_q  (flags[i])
      );
   end

   // R9
   stat_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !eoc_valid && !res_rd && !seq_start_wr) |=> $stable(flags));

   // R2
   low_pos_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_valid && eoc_pos < BASE_IDX && !res_rd && !seq_start_wr) |=> $stable(flags));

   // R9
   low_res_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_rd && res_idx < BASE_IDX && !eoc_valid && !seq_start_wr) |=> $stable(flags));

endmodule

// File: tb/sim_ccf_flag_bank.sv
`timescale 1ns/100ps
module sim_ccf_flag_bank;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       eoc_valid = 1'b0;
   logic [3:0] eoc_pos = '0;
   logic       seq_start_wr = 1'b0;
   logic       fast_clr = 1'b0;
   logic       stat_rd = 1'b0;
   logic       stat_wr = 1'b0;
   logic       res_rd = 1'b0;
   logic [3:0] res_idx = '0;
   logic [7:0] flags;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_f = '0;

   always #2.5 clk = ~clk;

   ccf_flag_bank u0 (
      .clk(clk), .rst_n(rst_n), .eoc_valid(eoc_valid), .eoc_pos(eoc_pos),
      .seq_start_wr(seq_start_wr), .fast_clr(fast_clr), .stat_rd(stat_rd),
      .stat_wr(stat_wr), .res_rd(res_rd), .res_idx(res_idx), .flags(flags)
   );

   task automatic chk(input string req, input logic [7:0] exp);
      checks++;
      if (flags !== exp) begin
         errors++;
         $display("FAIL %s: flags=%b expected=%b", req, flags, exp);
      end
   endtask

   // Drive one cycle of stimulus at a falling edge; the result is seen at the next falling edge
   task automatic cyc(input logic ev, input int ep, input logic st,
                      input logic srd, input logic swr, input logic rr, input int ri);
      eoc_valid = ev; eoc_pos = 4'(ep); seq_start_wr = st;
      stat_rd = srd; stat_wr = swr; res_rd = rr; res_idx = 4'(ri);
      @(negedge clk);
      eoc_valid = 0; seq_start_wr = 0; stat_rd = 0; stat_wr = 0; res_rd = 0;
   endtask

   function automatic logic [7:0] bit_of(input int pos);
      return (pos >= 8) ? (8'd1 << (pos - 8)) : 8'd0;
   endfunction

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: flags=%b expected=finish", flags);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      chk("R1 reset", 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 8'h00);

      // R2/R3: sweep all sixteen slots, low ones ignored, bits accumulate
      exp_f = '0;
      for (int p = 0; p < 16; p++) begin
         cyc(1, p, 0, 0, 0, 0, 0);
         exp_f |= bit_of(p);
         chk("R2 set sweep", exp_f);
      end
      repeat (3) @(negedge clk);
      chk("R3 sticky", 8'hFF);

      // R9: status write and low result reads leave bits alone
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk("R9 status write", 8'hFF);
      fast_clr = 1'b1;
      for (int r = 0; r < 8; r++) begin
         cyc(0, 0, 0, 0, 0, 1, r);
         chk("R9 low result read", 8'hFF);
      end

      // R7: fast mode, each result read clears its own bit
      exp_f = 8'hFF;
      for (int r = 8; r < 16; r++) begin
         cyc(0, 0, 0, 0, 0, 1, r);
         exp_f &= ~bit_of(r);
         chk("R7 fast clear", exp_f);
      end

      // R5: two-step mode, result read alone keeps bits
      fast_clr = 1'b0;
      for (int p = 8; p < 16; p++) cyc(1, p, 0, 0, 0, 0, 0);
      for (int r = 8; r < 16; r++) begin
         cyc(0, 0, 0, 0, 0, 1, r);
         chk("R5 no arm keeps", 8'hFF);
      end
      cyc(0, 0, 0, 1, 0, 0, 0);
      chk("R5 status read alone", 8'hFF);
      exp_f = 8'hFF;
      for (int r = 15; r >= 8; r--) begin
         cyc(0, 0, 0, 0, 0, 1, r);
         exp_f &= ~bit_of(r);
         chk("R5 armed clear", exp_f);
      end

      // R6: selective arm and single-use arm
      cyc(1, 8, 0, 0, 0, 0, 0);
      cyc(1, 10, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(1, 9, 0, 0, 0, 0, 0);
      chk("R6 before reads", 8'h07);
      for (int r = 8; r < 16; r++) cyc(0, 0, 0, 0, 0, 1, r);
      chk("R6 only armed cleared", 8'h02);
      cyc(1, 8, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 8);
      chk("R6 arm used up", 8'h03);

      // R4: sequence start wipes bits and arms
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 1, 0, 0, 0, 0);
      chk("R4 start clears", 8'h00);
      cyc(1, 11, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 11);
      chk("R4 arm dropped", 8'h08);
      cyc(1, 13, 1, 0, 0, 0, 0);
      chk("R4 start beats set", 8'h00);

      // R8: set wins over same-cycle clear, both modes
      fast_clr = 1'b1;
      cyc(1, 12, 0, 0, 0, 0, 0);
      cyc(1, 12, 0, 0, 0, 1, 12);
      chk("R8 set wins fast", 8'h10);
      fast_clr = 1'b0;
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(1, 12, 0, 0, 0, 1, 12);
      chk("R8 set wins two-step", 8'h10);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule